// File: doc/BRIEF.md
# Interleaved Compare Value Generator

This block sits beside the three compare registers of a PWM timer and produces the compare values the timer actually uses. In normal operation each compare channel is double-buffered: software writes land in a preload register and move to the active register on an update-event strobe. When an interleaved mode is selected, the block derives some or all compare values in hardware from the timer period. These values split the period into two, three or four equal phases.

While a channel is driven by hardware, software can still write to it. The written value is kept in that channel's preload register and does not disturb the active value. The first update event after the channel stops being hardware-driven makes the held value active. The block also raises a configuration-error flag when a three- or four-phase mode is combined with another feature that claims compare 2.

All pins are plain control and data levels sampled on the clock. There is no stream interface and no back-pressure. A write is accepted in every cycle its strobe is high, and an update strobe acts in the cycle it is seen.

Top module: `ilv_cmp_gen`

## Requirements
- R1: With mode_i = 01 (two-phase), cmp1_o equals floor(period/2), while cmp2_o and cmp3_o show their software active values.
- R2: With mode_i = 10 (three-phase), cmp1_o equals floor(period/3) and cmp2_o equals 2 x floor(period/3), while cmp3_o shows its software active value.
- R3: With mode_i = 11 (four-phase), cmp1_o equals floor(period/4), cmp2_o equals floor(period/2) and cmp3_o equals 3 x floor(period/4).
- R4: While a channel is hardware-driven, neither writes nor update strobes change the value it shows, nor the software active value it returns to later.
- R5: A write made while its channel is hardware-driven is held in preload. After the mode no longer drives that channel, the old active value is shown until the first update strobe, which makes the held value active.
- R6: With mode_i = 00, a write is not visible on the output until an update strobe. On the strobe, every channel takes the preload value it held before that clock edge.
- R7: Hardware-derived values and the choice between hardware and software values follow changes of period_i and mode_i one clock later.
- R8: cfg_err_o is high one clock after mode_i is 10 or 11 while cmp2_shared_i is high, and low otherwise.
- R9: After reset, all compare outputs and cfg_err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_i | input | 16 | Timer period value |
| mode_i | input | 2 | 00 none, 01 two-phase, 10 three-phase, 11 four-phase |
| cmp2_shared_i | input | 1 | Another feature is using compare 2 |
| wr_en_i | input | 3 | Write strobe per compare channel, bit 0 = compare 1 |
| wr_data_i | input | 16 | Data for the write |
| upd_i | input | 1 | Update-event strobe |
| cmp1_o | output | 16 | Compare 1 value in use |
| cmp2_o | output | 16 | Compare 2 value in use |
| cmp3_o | output | 16 | Compare 3 value in use |
| cfg_err_o | output | 1 | Compare 2 conflict with three- or four-phase mode |

## Verification
Suppose a channel wrongly takes an update while hardware-driven. The outputs would not show it during the mode. It would appear only in the cycle after the mode is left, as a new value where the old active value was expected, or at the next update as a missing step. A wrong quotient or a stale registered mode appears on the outputs one clock after period_i or mode_i changes. The bench therefore samples each output one cycle after every change, and again after the mode is exited both before and after the first update.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int NUM_CMP = 3;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_DUAL   = 2'b01,
    MODE_TRIPLE = 2'b10,
    MODE_QUAD   = 2'b11
  } ilv_mode_e;

  // Which compare channels the hardware owns in each mode (bit 0 = compare 1)
  function automatic logic [NUM_CMP-1:0] hw_mask(ilv_mode_e m);
    case (m)
      MODE_DUAL:   return 3'b001;
      MODE_TRIPLE: return 3'b011;
      MODE_QUAD:   return 3'b111;
      default:     return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/ilv_div_unit.sv
module ilv_div_unit
  import ilv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [W-1:0]              period_i,
  input  ilv_mode_e                 mode_i,
  output logic [NUM_CMP-1:0][W-1:0] hw_val_o,
  output logic [NUM_CMP-1:0]        hw_sel_o
);
  localparam int WX = W + 2;

  logic [W-1:0]  half, third, quarter;
  logic [WX-1:0] third_x2, quarter_x3;
  logic [NUM_CMP-1:0][W-1:0] val_d;

  always_comb begin
    half       = period_i >> 1;
    third      = period_i / W'(3);
    quarter    = period_i >> 2;
    // multiples are taken of the truncated quotient
    third_x2   = {2'b00, third} << 1;
    quarter_x3 = {2'b00, quarter} * WX'(3);
    val_d      = '0;
    case (mode_i)
      MODE_DUAL: val_d[0] = half;
      MODE_TRIPLE: begin
        val_d[0] = third;
        val_d[1] = third_x2[W-1:0];
      end
      MODE_QUAD: begin
        val_d[0] = quarter;
        val_d[1] = half;
        val_d[2] = quarter_x3[W-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_val_o <= '0;
      hw_sel_o <= '0;
    end else begin
      hw_val_o <= val_d;
      hw_sel_o <= hw_mask(mode_i);
    end
  end

  // a channel not owned by hardware never carries a derived value
  AST_UNOWNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_sel_o[2] |-> (hw_val_o[2] == '0)); // R7
endmodule

// File: rtl/ilv_cmp_chan.sv
module ilv_cmp_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         upd_i,
  input  logic         hw_sel_i,
  input  logic [W-1:0] hw_val_i,
  output logic [W-1:0] cmp_o
);
  logic [W-1:0] pre_q, act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_en_i) pre_q <= wr_data_i;
      if (upd_i && !hw_sel_i) act_q <= pre_q;
    end
  end

  assign cmp_o = hw_sel_i ? hw_val_i : act_q;

  AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hw_sel_i |=> $stable(act_q)); // R4
  AST_NO_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(act_q)); // R6
endmodule

// File: rtl/ilv_cmp_gen.sv
module ilv_cmp_gen
  import ilv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_i,
  input  logic [1:0]   mode_i,
  input  logic         cmp2_shared_i,
  input  logic [2:0]   wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         upd_i,
  output logic [W-1:0] cmp1_o,
  output logic [W-1:0] cmp2_o,
  output logic [W-1:0] cmp3_o,
  output logic         cfg_err_o
);
  localparam int WX = W + 2;

  ilv_mode_e                 mode_e;
  logic [NUM_CMP-1:0][W-1:0] hw_val;
  logic [NUM_CMP-1:0]        hw_sel;
  logic [NUM_CMP-1:0][W-1:0] cmp_val;
  logic                      cfg_err_q;
  logic                      started_q;

  assign mode_e = ilv_mode_e'(mode_i);

  ilv_div_unit #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .mode_i   (mode_e),
    .hw_val_o (hw_val),
    .hw_sel_o (hw_sel)
  );

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_chan
    ilv_cmp_chan #(.W(W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i[k]),
      .wr_data_i (wr_data_i),
      .upd_i     (upd_i),
      .hw_sel_i  (hw_sel[k]),
      .hw_val_i  (hw_val[k]),
      .cmp_o     (cmp_val[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_err_q <= 1'b0;
      started_q <= 1'b0;
    end else begin
      cfg_err_q <= mode_i[1] & cmp2_shared_i;
      started_q <= 1'b1;
    end
  end

  assign cmp1_o    = cmp_val[0];
  assign cmp2_o    = cmp_val[1];
  assign cmp3_o    = cmp_val[2];
  assign cfg_err_o = cfg_err_q;

  logic [WX-1:0] c1x, c2x, c3x;
  assign c1x = {2'b00, cmp1_o};
  assign c2x = {2'b00, cmp2_o};
  assign c3x = {2'b00, cmp3_o};

  AST_DUAL_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && $past(mode_i) == 2'b01) |->
      ((c1x << 1) <= {2'b00, $past(period_i)}) &&
      ((c1x << 1) + WX'(1) >= {2'b00, $past(period_i)})); // R1
  AST_TRIPLE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && $past(mode_i) == 2'b10) |->
      (c1x * WX'(3) <= {2'b00, $past(period_i)}) &&
      (c1x * WX'(3) + WX'(2) >= {2'b00, $past(period_i)}) &&
      (c2x == (c1x << 1))); // R2
  AST_QUAD_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && $past(mode_i) == 2'b11) |->
      ((c1x << 2) <= {2'b00, $past(period_i)}) &&
      ((c1x << 2) + WX'(3) >= {2'b00, $past(period_i)}) &&
      (c3x == c1x * WX'(3))); // R3
  AST_CFG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (cfg_err_o == ($past(mode_i[1]) && $past(cmp2_shared_i)))); // R8
endmodule

// File: tb/ilv_cmp_gen_tb_top.sv
module ilv_cmp_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period = '0;
  logic [1:0]  mode = 2'b00;
  logic        shared = 1'b0;
  logic [2:0]  wr_en = '0;
  logic [15:0] wr_data = '0;
  logic        upd = 1'b0;
  logic [15:0] c1, c2, c3;
  logic        err;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ilv_cmp_gen dut_i (
    .clk(clk), .rst_n(rst_n), .period_i(period), .mode_i(mode),
    .cmp2_shared_i(shared), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .upd_i(upd), .cmp1_o(c1), .cmp2_o(c2), .cmp3_o(c3), .cfg_err_o(err)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write(int ch, logic [15:0] v);
    wr_en = 3'b001 << ch;
    wr_data = v;
    tick();
    wr_en = '0;
  endtask

  task automatic update();
    upd = 1'b1;
    tick();
    upd = 1'b0;
  endtask

  task automatic set_mode(logic [1:0] m, logic [15:0] p);
    mode = m;
    period = p;
    tick();
  endtask

  task automatic t_reset();
    check("R9 cmp1", c1, 0);
    check("R9 cmp2", c2, 0);
    check("R9 cmp3", c3, 0);
    check("R9 cfg_err", {15'd0, err}, 0);
  endtask

  task automatic t_normal();
    set_mode(2'b00, 16'd1000);
    write(0, 16'd11);
    write(1, 16'd22);
    write(2, 16'd33);
    check("R6 no write-through", c1, 0);
    update();
    check("R6 cmp1", c1, 11);
    check("R6 cmp2", c2, 22);
    check("R6 cmp3", c3, 33);
    // write and update in the same cycle: old preload goes active
    wr_en = 3'b001; wr_data = 16'd99; upd = 1'b1;
    tick();
    wr_en = '0; upd = 1'b0;
    check("R6 simultaneous", c1, 11);
    update();
    check("R6 next update", c1, 99);
  endtask

  task automatic t_dual();
    logic [15:0] p = 16'd1001;
    set_mode(2'b01, p);
    check("R1 cmp1", c1, p / 2);
    check("R1 cmp2 soft", c2, 22);
    check("R1 cmp3 soft", c3, 33);
    write(1, 16'd77);
    update();
    check("R1 cmp2 updates in dual", c2, 77);
    check("R1 cmp1 held", c1, p / 2);
  endtask

  task automatic t_triple(logic [15:0] p);
    logic [15:0] q = p / 3;
    set_mode(2'b10, p);
    check("R2 cmp1", c1, q);
    check("R2 cmp2", c2, q * 2);
    check("R2 cmp3 soft", c3, 33);
  endtask

  task automatic t_quad(logic [15:0] p);
    logic [15:0] q = p / 4;
    set_mode(2'b11, p);
    check("R3 cmp1", c1, q);
    check("R3 cmp2", c2, p / 2);
    check("R3 cmp3", c3, q * 3);
  endtask

  task automatic t_hold_release();
    set_mode(2'b11, 16'd100);
    write(0, 16'd44);
    write(2, 16'd66);
    update();
    check("R4 cmp1 hw", c1, 25);
    check("R4 cmp3 hw", c3, 75);
    set_mode(2'b00, 16'd100);
    check("R5 cmp1 old active", c1, 99);
    check("R5 cmp2 old active", c2, 77);
    check("R5 cmp3 old active", c3, 33);
    update();
    check("R5 cmp1 released", c1, 44);
    check("R5 cmp3 released", c3, 66);
  endtask

  task automatic t_track();
    mode = 2'b11;
    period = 16'd400;
    @(posedge clk);
    #1;
    period = 16'd800;
    @(negedge clk);
    check("R7 one clock", c1, 100);
    tick();
    check("R7 follows", c1, 200);
  endtask

  task automatic t_cfg();
    shared = 1'b1;
    set_mode(2'b01, 16'd10);
    check("R8 dual no err", {15'd0, err}, 0);
    set_mode(2'b10, 16'd10);
    check("R8 triple err", {15'd0, err}, 1);
    set_mode(2'b11, 16'd10);
    check("R8 quad err", {15'd0, err}, 1);
    shared = 1'b0;
    tick();
    check("R8 cleared", {15'd0, err}, 0);
    set_mode(2'b00, 16'd10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_normal();
    t_dual();
    t_triple(16'd1001);
    t_triple(16'd7);
    t_triple(16'hFFFF);
    t_quad(16'd1001);
    t_quad(16'd7);
    t_quad(16'hFFFF);
    t_hold_release();
    t_track();
    t_cfg();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule